// File: doc/BRIEF.md
# RFID Modulation Line Encoder

This block sits between the frame sequencer of a read-only contactless tag and the load-modulation switch. It runs on the recovered carrier clock and counts carrier periods to mark off bit periods. At the last carrier cycle of each bit period it raises a one-cycle strobe. On that strobe the sequencer presents the next frame bit, and the encoder turns it into the level that drives the modulator. A low level turns the load switch on, so the coil draws heavy current. A high level turns the switch off.

Three line codes are built in. Manchester forces a level change at the middle of every bit. Biphase changes level at every bit boundary and adds a mid-bit change for a zero. PSK toggles on every carrier cycle and marks a zero by holding the level for one extra carrier cycle at the bit boundary. Manchester and biphase can use bit periods of 64 or 32 carrier cycles. PSK always uses 16. The code and the period are fixed while reset is held.

After reset the output stays high for one full bit period. The first frame bit is taken at the end of that idle period.

Top module: `rfid_line_encoder`

## Requirements
- R1: `bitStrobe` is high for exactly one carrier cycle, in the last cycle of each bit period. The first bit period starts at the first clock edge after reset is released.
- R2: `modeSel` 2'b00 selects Manchester, 2'b01 selects biphase, and 2'b10 or 2'b11 select PSK. In Manchester and biphase, `rateSel`=0 gives a 64-cycle bit period and `rateSel`=1 gives a 32-cycle bit period. PSK always uses a 16-cycle bit period.
- R3: While reset is held, `modCtrl` is high and `bitStrobe` is low. For the whole first bit period after release, `modCtrl` stays high.
- R4: In Manchester, a 1 is high for the first half of its period and low for the second half. A 0 is the reverse, so the level always changes at mid-bit.
- R5: In biphase, the level changes at the start of every bit. A 1 then holds its level for the whole bit. A 0 changes level again at mid-bit.
- R6: In PSK, the level toggles on every carrier cycle. The one exception is the first cycle of a 0 bit, where the level holds from the previous cycle (a phase flip). A 1 bit toggles there as usual.
- R7: `modeSel` and `rateSel` are sampled only while reset is held. Changing them after reset has no effect on the strobe timing or on `modCtrl`.
- R8: `dataIn` is captured only on the clock edge that ends a cycle in which `bitStrobe` is high. Its value at any other edge has no effect on `modCtrl`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier clock, one cycle per carrier period |
| rstN | input | 1 | Active-low reset; mode and rate are sampled while it is low |
| modeSel | input | 2 | Line code select (see R2) |
| rateSel | input | 1 | Bit period select for Manchester and biphase |
| dataIn | input | 1 | Next frame bit from the sequencer |
| bitStrobe | output | 1 | One-cycle pulse in the last cycle of each bit period |
| modCtrl | output | 1 | Modulator control; low means switch on |

## Verification
Each line code is run at each of its bit periods with frame patterns that mix alternating bits, long runs of ones and long runs of zeros. Alternating bits show that Manchester and biphase change level at the right moments. The runs separate the PSK phase flip from its steady toggling, and separate the biphase mid-bit change from a bit that holds its level. Between strobes the bench drives the inverse of the next bit, which shows that data is captured only at the boundary. After reset it also drives the opposite mode and rate, which shows that neither input is read once reset has been released.

// File: rtl/rfid_enc_pkg.sv
package rfid_enc_pkg;

  typedef enum logic [1:0] {
    MODE_MANCH   = 2'd0,
    MODE_BIPHASE = 2'd1,
    MODE_PSK     = 2'd2
  } enc_mode_e;

  // Strobes handed from control to datapath, all describing the next cycle
  typedef struct packed {
    logic      load;        // this edge closes a bit period, take new data
    logic      nextMid;     // next cycle is the first of the second half
    logic      nextSecond;  // next cycle lies in the second half
    logic      activeNext;  // encoding runs in the next cycle
    enc_mode_e mode;
  } enc_ctl_t;

  function automatic enc_mode_e decodeMode(input logic [1:0] sel);
    case (sel)
      2'b00:   return MODE_MANCH;
      2'b01:   return MODE_BIPHASE;
      default: return MODE_PSK;
    endcase
  endfunction

endpackage

// File: rtl/rfid_enc_ctrl.sv
module rfid_enc_ctrl
  import rfid_enc_pkg::*;
#(
  parameter int LONG_PERIOD  = 64,
  parameter int SHORT_PERIOD = 32,
  parameter int PSK_PERIOD   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       rateSel,
  output enc_ctl_t   ctl,
  output logic       bitStrobe
);

  localparam int CNT_W = $clog2(LONG_PERIOD);
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t LONG_LAST  = cnt_t'(LONG_PERIOD - 1);
  localparam cnt_t SHORT_LAST = cnt_t'(SHORT_PERIOD - 1);
  localparam cnt_t PSK_LAST   = cnt_t'(PSK_PERIOD - 1);
  localparam cnt_t LONG_HALF  = cnt_t'(LONG_PERIOD / 2);
  localparam cnt_t SHORT_HALF = cnt_t'(SHORT_PERIOD / 2);
  localparam cnt_t PSK_HALF   = cnt_t'(PSK_PERIOD / 2);

  enc_mode_e modeQ;
  logic      rateQ;
  cnt_t      lastCnt, halfCnt, cntQ, cntInc, cntNext;
  logic      activeQ, bitEnd;

  // Configuration is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= decodeMode(modeSel);
      rateQ <= rateSel;
    end
  end

  always_comb begin
    case (modeQ)
      MODE_PSK: begin
        lastCnt = PSK_LAST;
        halfCnt = PSK_HALF;
      end
      default: begin
        lastCnt = rateQ ? SHORT_LAST : LONG_LAST;
        halfCnt = rateQ ? SHORT_HALF : LONG_HALF;
      end
    endcase
  end

  assign bitEnd  = (cntQ == lastCnt);
  assign cntInc  = cntQ + cnt_t'(1);
  assign cntNext = bitEnd ? '0 : cntInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      activeQ <= 1'b0;
    end else begin
      cntQ    <= cntNext;
      activeQ <= activeQ | bitEnd;
    end
  end

  assign bitStrobe      = bitEnd;
  assign ctl.load       = bitEnd;
  assign ctl.nextMid    = !bitEnd && (cntInc == halfCnt);
  assign ctl.nextSecond = (cntNext >= halfCnt);
  assign ctl.activeNext = activeQ | bitEnd;
  assign ctl.mode       = modeQ;

  // R1: strobe never lasts longer than one cycle
  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> !bitStrobe);

  // R7: configuration does not move once reset is released
  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    $stable(modeQ) && $stable(rateQ));

endmodule

// File: rtl/rfid_enc_dpath.sv
module rfid_enc_dpath
  import rfid_enc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  enc_ctl_t ctl,
  input  logic     dataIn,
  output logic     modCtrl
);

  logic bitQ, bitNext, levelQ, levelNext;

  assign bitNext = ctl.load ? dataIn : bitQ;

  always_comb begin
    levelNext = 1'b1;
    if (ctl.activeNext) begin
      case (ctl.mode)
        MODE_MANCH:   levelNext = bitNext ^ ctl.nextSecond;
        MODE_BIPHASE: begin
          if (ctl.load)                     levelNext = ~levelQ;
          else if (ctl.nextMid && !bitNext) levelNext = ~levelQ;
          else                              levelNext = levelQ;
        end
        default:      levelNext = (ctl.load && !bitNext) ? levelQ : ~levelQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitQ   <= 1'b0;
      levelQ <= 1'b1;
    end else begin
      bitQ   <= bitNext;
      levelQ <= levelNext;
    end
  end

  assign modCtrl = levelQ;

  // R4: Manchester always changes level entering the second half
  assert_manch_mid_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == MODE_MANCH && ctl.activeNext && ctl.nextMid) |=> (modCtrl != $past(modCtrl)));

  // R5: biphase changes level at every bit start
  assert_biphase_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == MODE_BIPHASE && ctl.load) |=> (modCtrl != $past(modCtrl)));

  // R6: PSK toggles on every cycle inside a bit
  assert_psk_toggle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == MODE_PSK && ctl.activeNext && !ctl.load) |=> (modCtrl != $past(modCtrl)));

endmodule

// File: rtl/rfid_line_encoder.sv
module rfid_line_encoder
  import rfid_enc_pkg::*;
#(
  parameter int LONG_PERIOD  = 64,
  parameter int SHORT_PERIOD = 32,
  parameter int PSK_PERIOD   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       rateSel,
  input  logic       dataIn,
  output logic       bitStrobe,
  output logic       modCtrl
);

  enc_ctl_t ctl;

  rfid_enc_ctrl #(
    .LONG_PERIOD (LONG_PERIOD),
    .SHORT_PERIOD(SHORT_PERIOD),
    .PSK_PERIOD  (PSK_PERIOD)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .rateSel  (rateSel),
    .ctl      (ctl),
    .bitStrobe(bitStrobe)
  );

  rfid_enc_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .dataIn (dataIn),
    .modCtrl(modCtrl)
  );

endmodule

// File: tb/rfid_line_encoder_tb.sv
`timescale 1ns/1ps
module rfid_line_encoder_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       rateSel = 1'b0;
  logic       dataIn = 1'b0;
  logic       bitStrobe, modCtrl;
  int         compared = 0;
  int         mismatched = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  rfid_line_encoder u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .rateSel(rateSel),
    .dataIn(dataIn), .bitStrobe(bitStrobe), .modCtrl(modCtrl)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic runCfg(input logic [1:0] mode, input logic rate,
                        input logic [31:0] pat, input int nBits);
    int   n;
    logic lvl;
    logic expLvl;
    n = mode[1] ? 16 : (rate ? 32 : 64);
    rstN = 1'b0; modeSel = mode; rateSel = rate; dataIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 reset strobe", bitStrobe, 1'b0);
    check("R3 reset level", modCtrl, 1'b1);
    rstN = 1'b1;
    modeSel = ~mode;   // R7: ignored after reset
    rateSel = ~rate;
    lvl = 1'b1;
    for (int pos = 1; pos < (nBits + 1) * n; pos++) begin
      int   c;
      int   k;
      logic b;
      @(posedge clk);
      @(negedge clk);
      c = pos % n;
      k = pos / n - 1;
      if (k < 0) begin
        expLvl = 1'b1;
        check("R3 idle level", modCtrl, expLvl);
      end else begin
        b = pat[k];
        if (mode == 2'b00) begin
          expLvl = b ^ (c >= n / 2);
          check("R4 R7 R8 manchester level", modCtrl, expLvl);
        end else if (mode == 2'b01) begin
          if (c == 0) lvl = ~lvl;
          else if (c == n / 2 && !b) lvl = ~lvl;
          check("R5 R7 R8 biphase level", modCtrl, lvl);
        end else begin
          if (!(c == 0 && !b)) lvl = ~lvl;
          check("R6 R7 R8 psk level", modCtrl, lvl);
        end
      end
      check("R1 R2 R7 strobe timing", bitStrobe, logic'(c == n - 1));
      // R8: only the value present at the strobe edge may be taken
      if (c == n - 1) dataIn = pat[k + 1];
      else            dataIn = ~pat[k + 1];
    end
  endtask

  initial begin
    runCfg(2'b00, 1'b0, 32'hA5C3_0FF0, 20);
    runCfg(2'b00, 1'b1, 32'h000F_F0AA, 20);
    runCfg(2'b01, 1'b0, 32'h5555_F00F, 20);
    runCfg(2'b01, 1'b1, 32'hE07C_3A91, 20);
    runCfg(2'b10, 1'b0, 32'h3C0F_FA50, 24);
    runCfg(2'b11, 1'b1, 32'hAAAA_00FF, 24);
    runCfg(2'b10, 1'b1, 32'h0000_FFFF, 24);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule